// File: doc/BRIEF.md
# DDR Read Command Timing Scheduler

This block sits on the controller side of a DDR memory interface. It takes read requests and places READ, BURST TERMINATE and PRECHARGE commands on a registered command bus. Each request names a bank, a column, how many data elements are wanted, and whether the row should be closed afterwards. The memory fetches two elements per internal access, so every follow-up command is placed a number of cycles after its READ equal to the number of element pairs requested.

Follow-up commands work as follows. A short burst that leaves the row open is cut by a BURST TERMINATE. A burst that closes the row is cut, or followed, by a PRECHARGE to its bank. Each bank has two timers:
- a row-active timer, loaded from an activation notice, which holds back a PRECHARGE;
- a precharge timer, loaded when a PRECHARGE is issued, which holds back further READs to that bank.

A separate flag tells the write path when the read data has left the bus.

Top module: `ddr_rd_sched`

## Requirements
- R1: A request is accepted in the cycle `req_ready_o` is high. In the next cycle `cmd_o` shows READ (code 1), with the request's bank on `cmd_bank_o` and its column on `cmd_col_o`. The other codes are 0 = no command, 2 = BURST TERMINATE, 3 = PRECHARGE.
- R2: The pair count x of a request is the element count divided by two, rounded up. A count of 0 is treated as one pair, and x is capped at BL/2.
- R3: No READ appears earlier than x cycles after the previous READ. A waiting request whose bank is free appears exactly x cycles later when that READ needs no follow-up, which gives back-to-back data.
- R4: A request with fewer than BL/2 pairs and a clear close flag produces a BURST TERMINATE exactly x cycles after its READ.
- R5: A request with the close flag set produces a PRECHARGE to its bank x cycles after its READ. If the row-active time has not yet run out, the PRECHARGE comes in the first cycle after that in which it has.
- R6: A PRECHARGE to a bank appears no earlier than max(`cfg_tras_i`,1)+1 cycles after the cycle in which `act_i` named that bank.
- R7: No READ to a bank appears until max(`cfg_trp_i`,1) cycles after a PRECHARGE to that bank has appeared.
- R8: `wr_ok_o` is low from the cycle a READ appears for CL+x cycles, and high otherwise.
- R9: At most one command is issued per cycle. While a BURST TERMINATE or PRECHARGE is due, including a PRECHARGE held back by the row-active timer, `req_ready_o` stays low.
- R10: During and right after reset, `cmd_o` is 0, `req_ready_o` is 0 and `wr_ok_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Read request present |
| req_bank_i | input | BANK_W | Request bank |
| req_col_i | input | COL_W | Request starting column |
| req_len_i | input | LEN_W | Desired data element count |
| req_close_i | input | 1 | Close the row after this read |
| req_ready_o | output | 1 | Request accepted this cycle |
| act_i | input | 1 | A row activation was issued this cycle |
| act_bank_i | input | BANK_W | Bank of that activation |
| cfg_tras_i | input | TMR_W | Row-active minimum, in cycles |
| cfg_trp_i | input | TMR_W | Row-precharge time, in cycles |
| cmd_o | output | 2 | Command code (0 none, 1 READ, 2 BURST TERMINATE, 3 PRECHARGE) |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_col_o | output | COL_W | READ column |
| wr_ok_o | output | 1 | Write may be issued |

## Verification
The hardest case to reach is a PRECHARGE that falls due before its bank's row-active time has run out. It must then stall the whole command bus while other requests wait. The stimulus reaches it with a directed sequence: an activation with a long row-active setting, a short closing read to that bank right after it, and then a request to another bank. A read to the precharged bank is queued next so that the precharge timer is also exercised. Random runs under three timer settings, including zero, then mix back-to-back, odd-length and closing requests against a per-cycle reference model.

// File: rtl/rdsch_pkg.sv
package rdsch_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_READ = 2'd1,
    CMD_BST  = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    FU_NONE = 2'd0,
    FU_BST  = 2'd1,
    FU_PRE  = 2'd2
  } fu_e;

  // element count -> data pairs, at least one, capped at the burst
  function automatic int unsigned elem_pairs(int unsigned len, int unsigned bl);
    int unsigned p;
    p = (len + 1) / 2;
    if (p == 0) p = 1;
    if (p > bl / 2) p = bl / 2;
    return p;
  endfunction

  // timer load value: counter reaches zero after max(v,1) cycles
  function automatic int unsigned sat_dec(int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/rd_bank_timers.sv
module rd_bank_timers #(
  parameter int NBANK = 4,
  parameter int TMR_W = 6,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [TMR_W-1:0]  cfg_tras_i,
  input  logic [TMR_W-1:0]  cfg_trp_i,
  input  logic              pre_go,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic              rd_go,
  input  logic [BANK_W-1:0] rd_bank,
  output logic [NBANK-1:0]  tras_done,
  output logic [NBANK-1:0]  trp_done
);
  import rdsch_pkg::*;

  logic [TMR_W-1:0] tras_load, trp_load;
  assign tras_load = TMR_W'(sat_dec(32'(cfg_tras_i)));
  assign trp_load  = TMR_W'(sat_dec(32'(cfg_trp_i)));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [TMR_W-1:0] tras_cnt, trp_cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tras_cnt <= '0;
      end else if (act_i && act_bank_i == BANK_W'(b)) begin
        tras_cnt <= tras_load;
      end else if (tras_cnt != '0) begin
        tras_cnt <= tras_cnt - TMR_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trp_cnt <= '0;
      end else if (pre_go && pre_bank == BANK_W'(b)) begin
        trp_cnt <= trp_load;
      end else if (trp_cnt != '0) begin
        trp_cnt <= trp_cnt - TMR_W'(1);
      end
    end

    assign tras_done[b] = (tras_cnt == '0);
    assign trp_done[b]  = (trp_cnt == '0);
  end

  AST_PRE_AFTER_TRAS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |-> tras_done[pre_bank]); // R6

  AST_RD_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> trp_done[rd_bank]); // R7

endmodule

// File: rtl/rd_followup.sv
module rd_followup #(
  parameter int BL = 8,
  parameter int NBANK = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int PAIR_W = $clog2(BL / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [PAIR_W-1:0] rd_pairs,
  input  logic              rd_close,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic              fu_clear,
  output logic              slot_open,
  output logic              fu_due,
  output logic [1:0]        fu_kind,
  output logic [BANK_W-1:0] fu_bank
);
  import rdsch_pkg::*;

  logic [PAIR_W-1:0] gap_cnt;
  logic              short_burst;

  assign short_burst = rd_pairs < PAIR_W'(BL / 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      fu_kind <= FU_NONE;
      fu_bank <= '0;
    end else if (rd_go) begin
      gap_cnt <= rd_pairs - PAIR_W'(1);
      fu_bank <= rd_bank;
      if (rd_close)         fu_kind <= FU_PRE;
      else if (short_burst) fu_kind <= FU_BST;
      else                  fu_kind <= FU_NONE;
    end else begin
      if (gap_cnt != '0) gap_cnt <= gap_cnt - PAIR_W'(1);
      if (fu_clear)      fu_kind <= FU_NONE;
    end
  end

  assign slot_open = (gap_cnt == '0);
  assign fu_due    = slot_open && (fu_kind != FU_NONE);

  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (slot_open && !fu_due)); // R3

  AST_CLEAR_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    fu_clear |-> fu_due); // R9

endmodule

// File: rtl/rd_wr_guard.sv
module rd_wr_guard #(
  parameter int BL = 8,
  parameter int CL = 3,
  localparam int PAIR_W = $clog2(BL / 2 + 1),
  localparam int WCNT_W = $clog2(CL + BL / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [PAIR_W-1:0] rd_pairs,
  output logic              wr_ok
);
  logic [WCNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (rd_go) begin
      busy_cnt <= WCNT_W'(CL) + WCNT_W'(rd_pairs);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - WCNT_W'(1);
    end
  end

  assign wr_ok = (busy_cnt == '0);

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !wr_ok); // R8

endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched #(
  parameter int NBANK = 4,
  parameter int COL_W = 10,
  parameter int LEN_W = 4,
  parameter int BL    = 8,
  parameter int CL    = 3,
  parameter int TMR_W = 6,
  localparam int BANK_W = $clog2(NBANK),
  localparam int PAIR_W = $clog2(BL / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_close_i,
  output logic              req_ready_o,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [TMR_W-1:0]  cfg_tras_i,
  input  logic [TMR_W-1:0]  cfg_trp_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              wr_ok_o
);
  import rdsch_pkg::*;

  // named internal events
  logic              rd_go, bst_go, pre_go, fu_clear;
  logic [PAIR_W-1:0] req_pairs;
  logic              slot_open, fu_due;
  logic [1:0]        fu_kind;
  logic [BANK_W-1:0] fu_bank;
  logic [NBANK-1:0]  tras_done, trp_done;

  assign req_pairs = PAIR_W'(elem_pairs(32'(req_len_i), BL));

  assign bst_go   = fu_due && (fu_kind == FU_BST);
  assign pre_go   = fu_due && (fu_kind == FU_PRE) && tras_done[fu_bank];
  assign fu_clear = bst_go || pre_go;
  assign rd_go    = req_valid_i && slot_open && !fu_due && trp_done[req_bank_i];
  assign req_ready_o = rd_go;

  rd_followup #(.BL(BL), .NBANK(NBANK)) u_fu (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_go), .rd_pairs(req_pairs), .rd_close(req_close_i),
    .rd_bank(req_bank_i), .fu_clear(fu_clear),
    .slot_open(slot_open), .fu_due(fu_due), .fu_kind(fu_kind), .fu_bank(fu_bank)
  );

  rd_bank_timers #(.NBANK(NBANK), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .act_i(act_i), .act_bank_i(act_bank_i),
    .cfg_tras_i(cfg_tras_i), .cfg_trp_i(cfg_trp_i),
    .pre_go(pre_go), .pre_bank(fu_bank),
    .rd_go(rd_go), .rd_bank(req_bank_i),
    .tras_done(tras_done), .trp_done(trp_done)
  );

  rd_wr_guard #(.BL(BL), .CL(CL)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_go), .rd_pairs(req_pairs), .wr_ok(wr_ok_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
    end else if (bst_go) begin
      cmd_o      <= CMD_BST;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
    end else if (pre_go) begin
      cmd_o      <= CMD_PRE;
      cmd_bank_o <= fu_bank;
      cmd_col_o  <= '0;
    end else if (rd_go) begin
      cmd_o      <= CMD_READ;
      cmd_bank_o <= req_bank_i;
      cmd_col_o  <= req_col_i;
    end else begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, bst_go, pre_go})); // R9

  AST_READ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (cmd_o == CMD_READ)); // R1

endmodule

// File: tb/tb_ddr_rd_sched.sv
`timescale 1ns/1ps
module tb_ddr_rd_sched;
  localparam int NB = 4;
  localparam int BL = 8;
  localparam int CL = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid_i, req_close_i, req_ready_o;
  logic [1:0] req_bank_i, act_bank_i, cmd_bank_o;
  logic [9:0] req_col_i, cmd_col_o;
  logic [3:0] req_len_i;
  logic       act_i, wr_ok_o;
  logic [5:0] cfg_tras_i, cfg_trp_i;
  logic [1:0] cmd_o;

  always #2.5 clk = ~clk;

  ddr_rd_sched dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_bank_i(req_bank_i), .req_col_i(req_col_i),
    .req_len_i(req_len_i), .req_close_i(req_close_i), .req_ready_o(req_ready_o),
    .act_i(act_i), .act_bank_i(act_bank_i),
    .cfg_tras_i(cfg_tras_i), .cfg_trp_i(cfg_trp_i),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_col_o(cmd_col_o), .wr_ok_o(wr_ok_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state, in decision-cycle numbers
  int d = 0;
  int next_slot = 0;
  int pend_kind = 0;              // 0 none, 2 terminate, 3 precharge
  int pend_bank = 0;
  int pre_from [NB];
  int read_from [NB];
  int write_from = 0;
  int exp_cmd = 0, exp_bank = 0, exp_col = 0;
  string exp_tag = "R10";

  bit have_req = 0;
  bit force_act = 0;
  int force_act_bank = 0;

  task automatic chk(bit ok, string tag, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  function automatic int pair_count(int elems);
    int n;
    n = elems / 2 + elems % 2;
    if (n < 1) n = 1;
    if (n > BL / 2) n = BL / 2;
    return n;
  endfunction

  function automatic int at_least_one(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic set_req(int bank, int col, int len, bit close_row);
    have_req    = 1;
    req_bank_i  = 2'(bank);
    req_col_i   = 10'(col);
    req_len_i   = 4'(len);
    req_close_i = close_row;
  endtask

  // one decision cycle: drive, predict, cross the edge, compare
  task automatic step(int p_req, int p_act, int p_close);
    bit due, rdy;
    string rtag;
    int n;
    if (!have_req && ($urandom % 100) < p_req)
      set_req($urandom % NB, $urandom % 1024, $urandom % 16, ($urandom % 100) < p_close);
    req_valid_i = have_req;
    if (force_act) begin
      act_i = 1'b1; act_bank_i = 2'(force_act_bank); force_act = 0;
    end else begin
      act_i = (($urandom % 100) < p_act); act_bank_i = 2'($urandom % NB);
    end
    #1;
    due = (pend_kind != 0) && (d >= next_slot);
    rdy = 0; exp_cmd = 0; exp_bank = 0; exp_col = 0;
    exp_tag = "R9"; rtag = "R9";
    if (due) begin
      if (pend_kind == 2) begin
        exp_cmd = 2; exp_tag = "R4 (pairs from R2)"; pend_kind = 0;
      end else if (d >= pre_from[pend_bank]) begin
        exp_cmd = 3; exp_bank = pend_bank; exp_tag = "R5"; pend_kind = 0;
        read_from[pend_bank] = d + at_least_one(int'(cfg_trp_i));
      end else begin
        exp_tag = "R6"; rtag = "R9";
      end
    end else if (have_req) begin
      if (d < next_slot) rtag = "R3";
      else if (d < read_from[req_bank_i]) rtag = "R7";
      else begin
        rdy = 1; rtag = "R1"; exp_tag = "R1";
        n = pair_count(int'(req_len_i));
        exp_cmd = 1; exp_bank = int'(req_bank_i); exp_col = int'(req_col_i);
        next_slot = d + n;
        pend_bank = int'(req_bank_i);
        if (req_close_i) pend_kind = 3;
        else if (n < BL / 2) pend_kind = 2;
        else pend_kind = 0;
        write_from = d + 1 + CL + n;
      end
    end
    chk(req_ready_o == rdy, rtag, "req_ready_o", int'(req_ready_o), int'(rdy));
    if (act_i) pre_from[act_bank_i] = d + at_least_one(int'(cfg_tras_i));
    if (rdy) have_req = 0;
    d++;
    @(negedge clk);
    chk(int'(cmd_o) == exp_cmd, exp_tag, "cmd_o", int'(cmd_o), exp_cmd);
    if (exp_cmd == 1) begin
      chk(int'(cmd_bank_o) == exp_bank, "R1", "cmd_bank_o", int'(cmd_bank_o), exp_bank);
      chk(int'(cmd_col_o) == exp_col, "R1", "cmd_col_o", int'(cmd_col_o), exp_col);
    end
    if (exp_cmd == 3)
      chk(int'(cmd_bank_o) == exp_bank, "R5", "cmd_bank_o", int'(cmd_bank_o), exp_bank);
    chk(wr_ok_o == (d >= write_from), "R8", "wr_ok_o", int'(wr_ok_o), int'(d >= write_from));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin pre_from[b] = 0; read_from[b] = 0; end
    rst_n = 0; req_valid_i = 0; req_bank_i = 0; req_col_i = 0; req_len_i = 0;
    req_close_i = 0; act_i = 0; act_bank_i = 0; cfg_tras_i = 6'd10; cfg_trp_i = 6'd4;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(cmd_o == 2'd0, "R10", "cmd_o", int'(cmd_o), 0);
    chk(req_ready_o == 1'b0, "R10", "req_ready_o", int'(req_ready_o), 0);
    chk(wr_ok_o == 1'b1, "R10", "wr_ok_o", int'(wr_ok_o), 1);
    rst_n = 1;

    // full burst, no follow-up (R1, R8)
    set_req(1, 5, 8, 0);
    step(0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0);
    // odd length: 5 elements -> 3 pairs -> terminate (R2, R4)
    set_req(2, 77, 5, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0);
    // stalled precharge: activation, then close request (R6, R9)
    force_act = 1; force_act_bank = 0;
    step(0, 0, 0);
    set_req(0, 12, 3, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    set_req(3, 40, 2, 0);
    for (int i = 0; i < 14; i++) step(0, 0, 0);
    // read to the precharged bank waits for tRP (R7)
    force_act = 1; force_act_bank = 0;
    step(0, 0, 0);
    set_req(0, 9, 2, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0);
    set_req(0, 10, 8, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0);
    // back-to-back full bursts (R3)
    set_req(1, 1, 8, 0);
    step(0, 0, 0);
    set_req(2, 2, 8, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0);

    // random traffic under several timer settings
    for (int i = 0; i < 4000; i++) step(60, 10, 40);
    cfg_tras_i = 6'd0; cfg_trp_i = 6'd0;
    for (int i = 0; i < 4000; i++) step(70, 15, 50);
    cfg_tras_i = 6'd20; cfg_trp_i = 6'd7;
    for (int i = 0; i < 4000; i++) step(60, 8, 30);

    done = 1;
    finish_run();
  end

endmodule